// File: doc/BRIEF.md
# Power-Up Initialization and Bus Address Sequencer

This block controls the start-up of a digitally configured regulator. While the supply is below its undervoltage threshold, the block holds everything idle. Once the supply-good input rises, it runs an ordered sequence of steps. First it reads a fixed number of configuration words from a non-volatile memory port and writes each one into the working register file. Then it captures a two-bit address-strap code and forms the 7-bit serial-bus target address from that code. Only then does it raise its ready flags.

Two things wait on the ready state. The serial-bus slave is enabled by `bus_en`. An output-enable request passes through to `out_en` only while initialization is complete. If supply-good drops at any point, the sequencer returns to its idle state. A later rise of supply-good runs the whole sequence again, including a fresh read of the strap.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, `init_done`, `bus_en`, `out_en`, `mem_req` and `reg_wr` are all 0, and `bus_addr` is 0x08.
- R2: In the cycle after the first clock edge that samples `supply_ok` high, `mem_req` is 1 and `mem_addr` is 0.
- R3: The block fetches memory words in ascending index order, 0 to NUM_WORDS-1. While `mem_req` is 1, a high `mem_ack` puts `reg_wr` high in that same cycle. In that cycle `reg_wr_addr` equals `mem_addr` and `reg_wr_data` equals `mem_data`. After the clock edge, `mem_addr` has advanced by one.
- R4: Call the clock edge that samples the acknowledge for the last word edge E. In the cycle after E, `mem_req` is 0 and `init_done` is still 0. After the next edge, `init_done` and `bus_en` are both 1.
- R5: When ready, `bus_addr` is 0x08 plus the strap code. The two-flop synchronized strap code is taken as an unsigned 0 to 3, so the address is 0x08, 0x09, 0x0A or 0x0B.
- R6: While the block stays ready, a change of `strap_code` does not change `bus_addr`.
- R7: `out_en` equals `out_en_req` while `init_done` is 1, and is 0 otherwise.
- R8: A clock edge that samples `supply_ok` low clears the block in the following cycle. `init_done`, `bus_en`, `mem_req` and `out_en` go to 0, and `bus_addr` returns to 0x08. A later rise of `supply_ok` restarts the sequence at word 0 and captures the strap again.
- R9: `mem_ack` while `mem_req` is 0 is ignored: `reg_wr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply is above the undervoltage start threshold |
| mem_req | output | 1 | Memory word request |
| mem_addr | output | MAW | Index of the requested word |
| mem_ack | input | 1 | Memory word valid |
| mem_data | input | DW | Memory word |
| strap_code | input | 2 | Asynchronous address-strap code |
| out_en_req | input | 1 | Output-enable request |
| reg_wr | output | 1 | Working-register write strobe |
| reg_wr_addr | output | MAW | Working-register index |
| reg_wr_data | output | DW | Working-register data |
| bus_addr | output | 7 | Serial-bus target address |
| init_done | output | 1 | Initialization complete |
| bus_en | output | 1 | Serial-bus slave enable |
| out_en | output | 1 | Gated output enable |

## Verification
A wrong state register shows up within one cycle at the ports. It appears as a `mem_req` level that disagrees with the load phase, or as a ready flag that rises without the two-cycle tail after the last write. A wrong word counter shows up on the next acknowledged write, as a `reg_wr_addr` out of sequence or a missing or extra write. A wrong offset register appears in `bus_addr` as soon as the block is ready, or after the strap changes while the block runs. A missing clear on supply loss shows in the following cycle.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STRAP = 2'd2,
    ST_READY = 2'd3
  } seq_state_t;

  // Target address = base plus two-bit strap offset
  function automatic logic [6:0] make_bus_addr(input logic [6:0] base,
                                               input logic [1:0] ofs);
    return base + {5'b00000, ofs};
  endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/pwrup_loader.sv
module pwrup_loader #(
  parameter int NUM_WORDS = 8,
  parameter int DW        = 8,
  parameter int MAW       = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_data,
  output logic           mem_req,
  output logic [MAW-1:0] mem_addr,
  output logic           wr_en,
  output logic [MAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           load_done
);
  localparam logic [MAW-1:0] LAST_IDX = MAW'(NUM_WORDS - 1);

  logic [MAW-1:0] idx_q;
  logic           fire;
  logic           at_last;

  assign mem_req   = active;
  assign mem_addr  = idx_q;
  assign fire      = active & mem_ack;
  assign at_last   = (idx_q == LAST_IDX);
  assign load_done = fire & at_last;
  assign wr_en     = fire;
  assign wr_addr   = idx_q;
  assign wr_data   = mem_data;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      idx_q <= '0;
    end else if (fire) begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
    end
  end

  // R3: an accepted non-final word moves the index forward by one
  assert_index_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !at_last) |=> (!active || mem_addr == MAW'($past(mem_addr) + 1'b1)));

  // R3: index never leaves the word range
  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr <= LAST_IDX));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int          NUM_WORDS = 8,
  parameter int          DW        = 8,
  parameter logic [6:0]  BASE_ADDR = 7'h08,
  localparam int         MAW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           supply_ok,
  output logic           mem_req,
  output logic [MAW-1:0] mem_addr,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_data,
  input  logic [1:0]     strap_code,
  input  logic           out_en_req,
  output logic           reg_wr,
  output logic [MAW-1:0] reg_wr_addr,
  output logic [DW-1:0]  reg_wr_data,
  output logic [6:0]     bus_addr,
  output logic           init_done,
  output logic           bus_en,
  output logic           out_en
);
  seq_state_t state_q, state_d;
  logic [1:0] strap_sync;
  logic [1:0] offset_q;
  logic       load_active;
  logic       load_done;
  logic       strap_capture;

  pwrup_sync #(.W(2)) u_strap_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (strap_code),
    .dout (strap_sync)
  );

  assign load_active   = (state_q == ST_LOAD);
  assign strap_capture = (state_q == ST_STRAP);

  pwrup_loader #(.NUM_WORDS(NUM_WORDS), .DW(DW), .MAW(MAW)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (load_active),
    .mem_ack  (mem_ack),
    .mem_data (mem_data),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .wr_en    (reg_wr),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .load_done(load_done)
  );

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   state_d = ST_LOAD;
        ST_LOAD:  if (load_done) state_d = ST_STRAP;
        ST_STRAP: state_d = ST_READY;
        ST_READY: state_d = ST_READY;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      offset_q <= 2'b00;
    end else begin
      state_q <= state_d;
      if (!supply_ok)         offset_q <= 2'b00;
      else if (strap_capture) offset_q <= strap_sync;
    end
  end

  assign init_done = (state_q == ST_READY);
  assign bus_en    = init_done;
  assign bus_addr  = make_bus_addr(BASE_ADDR, offset_q);
  assign out_en    = out_en_req & init_done;

  // R4: ready is entered only right after the strap capture cycle
  assert_ready_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(strap_capture));

  // R5: address stays in the four-entry window
  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= BASE_ADDR) && (bus_addr <= 7'(BASE_ADDR + 7'd3)));

  // R6: address frozen while running
  assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |-> $stable(bus_addr));

  // R7: output enable never ahead of the bus enable
  assert_out_en_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> bus_en);

  // R8: supply loss clears the ready flags and the request
  assert_drop_on_uvlo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!init_done && !bus_en && !mem_req));

  // R9: register writes only occur in the load phase
  assert_write_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (state_q == ST_LOAD));
endmodule

// File: tb/pwrup_seq_test.sv
module pwrup_seq_test;
  localparam int NW  = 8;
  localparam int DW  = 8;
  localparam int MAW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           supply_ok = 1'b0;
  logic           mem_req;
  logic [MAW-1:0] mem_addr;
  logic           mem_ack = 1'b0;
  logic [DW-1:0]  mem_data = '0;
  logic [1:0]     strap_code = 2'd2;
  logic           out_en_req = 1'b0;
  logic           reg_wr;
  logic [MAW-1:0] reg_wr_addr;
  logic [DW-1:0]  reg_wr_data;
  logic [6:0]     bus_addr;
  logic           init_done, bus_en, out_en;

  int tests = 0;
  int fails = 0;
  int writes_seen = 0;
  int round = 0;
  bit force_ack = 1'b0;
  bit done_flag = 1'b0;

  typedef struct packed { logic [MAW-1:0] a; logic [DW-1:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  always #5 clk = ~clk;

  pwrup_seq #(.NUM_WORDS(NW), .DW(DW), .BASE_ADDR(7'h08)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .strap_code(strap_code), .out_en_req(out_en_req),
    .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .bus_addr(bus_addr), .init_done(init_done), .bus_en(bus_en), .out_en(out_en)
  );

  function automatic logic [6:0] want_addr(input logic [1:0] s);
    return 7'h08 | {5'b0, s};
  endfunction

  function automatic logic [DW-1:0] pattern(input logic [MAW-1:0] a, input int r);
    return DW'(int'(a) * 37 + r * 11 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic low_phase();
    @(negedge clk); #2;
  endtask

  // Driver: memory responder, pushes expected writes
  int gap = 0;
  int next_idx = 0;
  always @(negedge clk) begin
    if (force_ack) begin
      mem_ack <= 1'b1;
    end else if (mem_req && !mem_ack && gap == 0) begin
      check(int'(mem_addr) == next_idx, "R3 fetch order", int'(mem_addr), next_idx);
      mem_ack  <= 1'b1;
      mem_data <= pattern(mem_addr, round);
      exp_q.push_back('{a: mem_addr, d: pattern(mem_addr, round)});
      next_idx = next_idx + 1;
      gap = (next_idx % 3);
    end else begin
      mem_ack <= 1'b0;
      if (gap > 0 && mem_req) gap = gap - 1;
      if (!mem_req) next_idx = 0;
    end
  end

  // Monitor: pops and compares register writes
  always begin
    @(negedge clk); #2;
    if (reg_wr) begin
      writes_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected write", int'(reg_wr_addr), -1);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(reg_wr_addr == it.a, "R3 write index", int'(reg_wr_addr), int'(it.a));
        check(reg_wr_data == it.d, "R3 write data", int'(reg_wr_data), int'(it.d));
      end
    end
  end

  task automatic wait_last_write_and_ready(input logic [1:0] s);
    int n = 0;
    while (!(reg_wr && reg_wr_addr == MAW'(NW - 1)) && n < 2000) begin
      low_phase(); n++;
    end
    check(n < 2000, "R3 last word reached", n, 0);
    low_phase();
    check(!mem_req && !init_done, "R4 tail cycle", {mem_req, init_done}, 0);
    low_phase();
    check(init_done && bus_en, "R4 ready flags", {init_done, bus_en}, 3);
    check(bus_addr == want_addr(s), "R5 bus address", bus_addr, want_addr(s));
  endtask

  task automatic power_up(input logic [1:0] s);
    strap_code = s;
    repeat (4) low_phase();
    @(negedge clk);
    round++;
    supply_ok = 1'b1;
    low_phase();
    check(mem_req && mem_addr == 0, "R2 start at word 0", {mem_req, mem_addr}, 8);
  endtask

  task automatic power_down();
    @(negedge clk);
    supply_ok = 1'b0;
    low_phase();
    check(!init_done && !bus_en && !mem_req && !out_en,
          "R8 cleared", {init_done, bus_en, mem_req, out_en}, 0);
    check(bus_addr == 7'h08, "R8 address reset", bus_addr, 8);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    low_phase();
    check(!init_done && !bus_en && !out_en && !mem_req && !reg_wr,
          "R1 reset outputs", {init_done, bus_en, out_en, mem_req, reg_wr}, 0);
    check(bus_addr == 7'h08, "R1 reset address", bus_addr, 8);

    // R9: acknowledge while idle
    @(negedge clk); force_ack = 1'b1;
    repeat (3) begin
      low_phase();
      check(!reg_wr, "R9 idle ack ignored", reg_wr, 0);
    end
    @(negedge clk); force_ack = 1'b0;
    low_phase();
    check(writes_seen == 0, "R9 no writes while idle", writes_seen, 0);

    // First start-up, strap 2, enable requested early
    out_en_req = 1'b1;
    power_up(2'd2);
    check(!out_en, "R7 enable held during load", out_en, 0);
    wait_last_write_and_ready(2'd2);
    check(out_en, "R7 enable passes when ready", out_en, 1);
    @(negedge clk); out_en_req = 1'b0;
    low_phase();
    check(!out_en, "R7 enable follows request", out_en, 0);
    out_en_req = 1'b1;

    // R6: strap changes while running
    strap_code = 2'd1;
    repeat (6) low_phase();
    check(bus_addr == want_addr(2'd2), "R6 address frozen", bus_addr, want_addr(2'd2));

    power_down();

    // Restart with other straps
    power_up(2'd1);
    wait_last_write_and_ready(2'd1);
    power_down();
    power_up(2'd3);
    wait_last_write_and_ready(2'd3);
    power_down();

    // Abort mid-load, then full load with strap 0
    power_up(2'd0);
    repeat (3) low_phase();
    power_down();
    check(!init_done, "R8 abort stays idle", init_done, 0);
    power_up(2'd0);
    wait_last_write_and_ready(2'd0);

    repeat (3) low_phase();
    check(exp_q.size() == 0, "R3 all writes observed", exp_q.size(), 0);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule